// File: doc/BRIEF.md
# Triple-Redundant Scan-State Compare and Repair Controller

This block supervises three identical redundant modules whose internal flip-flops are each reachable through a scan chain of `CHAIN_LEN` bits. In normal operation the chains are idle. When the output voter reports a disagreement, or a periodic checkpoint pulse arrives, the controller starts a comparison pass. It rotates all three chains once around, so that every module ends that pass holding its own original state. On each bit it notes which module, if any, disagrees with the other two. The result is a mask of faulty modules. This catches latent faults that never reached a module output.

A non-empty mask with at least one clean module starts a second, repair pass of `CHAIN_LEN` cycles. Each clean module rotates its own chain. Each faulty module is loaded from the scan-out of the lowest-numbered clean module. The block then returns to normal operation. If every module was marked faulty, the controller stops in a halted phase, raises `halt_o`, and stays there until reset.

Top module: `tmr_scan_ctrl`

## Requirements
- R1: After reset the phase is normal (`phase_o` = 0), `se_o` = 3'b000, `si_o` = 3'b000, `halt_o` = 0 and `fault_mask_o` = 3'b000.
- R2: In the normal phase with no request, all scan enables stay low, so the module states do not change and the phase stays normal.
- R3: A high `err_req_i` or `chkpt_i` sampled at a clock edge in the normal phase moves the block to comparison (`phase_o` = 1) at that edge. Comparison lasts exactly `CHAIN_LEN` cycles with `se_o` = 3'b111 and `si_o[i]` = `so_i[i]` for every lane, so the states are unchanged after the pass.
- R4: During comparison, for each scanned bit, a module whose bit differs from the two others, which agree with each other, gets its bit set in the fault mask. Bit i of `fault_mask_o` stands for module i. The mask accumulates over the whole pass and is shown on `fault_mask_o` in the repair and halted phases.
- R5: If the accumulated mask is zero at the end of comparison, the block returns to normal directly and the module states are unchanged.
- R6: If one or two modules are marked, the block enters repair (`phase_o` = 2) for exactly `CHAIN_LEN` cycles with `se_o` = 3'b111. A clean lane gets `si_o[i]` = `so_i[i]`. A marked lane gets the `so_i` of the lowest-indexed clean module. Afterwards all three states equal that module's state.
- R7: If all three modules are marked, the block enters the halted phase (`phase_o` = 3). In that phase `halt_o` = 1 and `se_o` = 3'b000, and the phase holds until reset.
- R8: Requests that arrive during comparison or repair are ignored: the pass lengths do not change and no new pass follows. On return to normal the fault mask reads 3'b000.
- R9: `err_req_i` and `chkpt_i` high in the same cycle start exactly one comparison pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| err_req_i | input | 1 | Mismatch request from the output voter |
| chkpt_i | input | 1 | Checkpoint pulse |
| so_i | input | 3 | Scan-out of modules 2..0 |
| se_o | output | 3 | Scan enable of modules 2..0 |
| si_o | output | 3 | Scan-in of modules 2..0 |
| phase_o | output | 2 | 0 normal, 1 comparison, 2 repair, 3 halted |
| fault_mask_o | output | 3 | Accumulated faulty-module mask |
| halt_o | output | 1 | Unrecoverable, system halted |

## Verification
Two things can fall in the same cycle: a fresh request, and the last bit of a pass, when the controller is deciding its next phase. Request pulses are also placed on the same cycle as each other, and part-way through comparison. The bench judges the outcome by measuring both pass lengths, by checking that the block stays in normal afterwards, and by comparing the final module states against a bench model of the three chains. Random sparse bit flips across one, two or all three modules cover repair from either clean source as well as the halted outcome.

// File: rtl/tmr_scan_pkg.sv
package tmr_scan_pkg;
  typedef enum logic [1:0] {
    PH_NORM = 2'd0,
    PH_CMP  = 2'd1,
    PH_REC  = 2'd2,
    PH_HALT = 2'd3
  } phase_e;
endpackage

// File: rtl/tmr_bit_cnt.sv
module tmr_bit_cnt #(
  parameter int CHAIN_LEN = 16,
  localparam int CW = (CHAIN_LEN > 2) ? $clog2(CHAIN_LEN) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic last_o
);
  logic [CW-1:0] cnt_q;

  assign last_o = (cnt_q == CW'(CHAIN_LEN - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (clr_i)    cnt_q <= '0;
    else if (en_i)     cnt_q <= cnt_q + 1'b1;
  end

  // R3
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(CHAIN_LEN) || CHAIN_LEN == (1 << CW));
endmodule

// File: rtl/tmr_odd_locator.sv
module tmr_odd_locator (
  input  logic [2:0] bits_i,
  output logic [2:0] odd_o
);
  // a lane is odd when the other two agree and it differs from them
  always_comb begin
    odd_o[0] = (bits_i[1] == bits_i[2]) && (bits_i[0] != bits_i[1]);
    odd_o[1] = (bits_i[0] == bits_i[2]) && (bits_i[1] != bits_i[0]);
    odd_o[2] = (bits_i[0] == bits_i[1]) && (bits_i[2] != bits_i[0]);
  end

  // R4
  odd_single_chk: assert final ($onehot0(odd_o));
endmodule

// File: rtl/tmr_scan_route.sv
module tmr_scan_route
  import tmr_scan_pkg::*;
#(
  parameter int LANES = 3
) (
  input  phase_e           phase_i,
  input  logic [LANES-1:0] mask_i,
  input  logic [LANES-1:0] so_i,
  output logic [LANES-1:0] se_o,
  output logic [LANES-1:0] si_o
);
  logic src_bit;

  // lowest-indexed clean lane feeds all marked lanes
  always_comb begin
    src_bit = 1'b0;
    for (int k = LANES - 1; k >= 0; k--) begin
      if (!mask_i[k]) src_bit = so_i[k];
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_comb begin
      se_o[g] = (phase_i == PH_CMP) || (phase_i == PH_REC);
      si_o[g] = 1'b0;
      if (phase_i == PH_CMP)      si_o[g] = so_i[g];
      else if (phase_i == PH_REC) si_o[g] = mask_i[g] ? src_bit : so_i[g];
    end
  end
endmodule

// File: rtl/tmr_scan_ctrl.sv
module tmr_scan_ctrl
  import tmr_scan_pkg::*;
#(
  parameter int CHAIN_LEN = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       err_req_i,
  input  logic       chkpt_i,
  input  logic [2:0] so_i,
  output logic [2:0] se_o,
  output logic [2:0] si_o,
  output logic [1:0] phase_o,
  output logic [2:0] fault_mask_o,
  output logic       halt_o
);
  phase_e     phase_q, phase_d;
  logic [2:0] mask_q, mask_d, odd, mask_acc;
  logic       last, req;

  assign req      = err_req_i | chkpt_i;
  assign mask_acc = mask_q | odd;

  tmr_bit_cnt #(.CHAIN_LEN(CHAIN_LEN)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  ((phase_q == PH_NORM) || (phase_q == PH_HALT) || last),
    .en_i   ((phase_q == PH_CMP) || (phase_q == PH_REC)),
    .last_o (last)
  );

  tmr_odd_locator u_loc (
    .bits_i (so_i),
    .odd_o  (odd)
  );

  tmr_scan_route #(.LANES(3)) u_route (
    .phase_i (phase_q),
    .mask_i  (mask_q),
    .so_i    (so_i),
    .se_o    (se_o),
    .si_o    (si_o)
  );

  always_comb begin
    phase_d = phase_q;
    mask_d  = mask_q;
    unique case (phase_q)
      PH_NORM: begin
        mask_d = '0;
        if (req) phase_d = PH_CMP;
      end
      PH_CMP: begin
        mask_d = mask_acc;
        if (last) begin
          if (mask_acc == 3'b000)      begin phase_d = PH_NORM; mask_d = '0; end
          else if (mask_acc == 3'b111) phase_d = PH_HALT;
          else                         phase_d = PH_REC;
        end
      end
      PH_REC: begin
        if (last) begin
          phase_d = PH_NORM;
          mask_d  = '0;
        end
      end
      PH_HALT: ;
      default: phase_d = PH_NORM;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_NORM;
      mask_q  <= '0;
    end else begin
      phase_q <= phase_d;
      mask_q  <= mask_d;
    end
  end

  assign phase_o      = phase_q;
  assign fault_mask_o = mask_q;
  assign halt_o       = (phase_q == PH_HALT);

  // R3
  req_enter_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_NORM && req) |=> (phase_q == PH_CMP));
  // R6
  rec_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_REC) |-> (mask_q != 3'b000 && mask_q != 3'b111));
  // R7
  halt_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> halt_o);
  // R7
  halt_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> (se_o == 3'b000));
  // R8
  mask_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_NORM) |=> (phase_q != PH_NORM || mask_q == 3'b000));
endmodule

// File: tb/tb_tmr_scan_ctrl.sv
module tb_tmr_scan_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int L = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic err_req = 1'b0, chkpt = 1'b0;
  logic [2:0] so, se, si, mask;
  logic [1:0] phase;
  logic halt;

  logic [L-1:0] mod_q [3];
  logic [L-1:0] flip [3];
  logic inj_v = 1'b0;

  int checks = 0, errors = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_scan_ctrl #(.CHAIN_LEN(L)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .err_req_i(err_req), .chkpt_i(chkpt),
    .so_i(so), .se_o(se), .si_o(si), .phase_o(phase),
    .fault_mask_o(mask), .halt_o(halt)
  );

  // bench model of the three redundant chains
  assign so = {mod_q[2][0], mod_q[1][0], mod_q[0][0]};
  always @(posedge clk) begin
    for (int i = 0; i < 3; i++) begin
      if (inj_v)      mod_q[i] <= mod_q[i] ^ flip[i];
      else if (se[i]) mod_q[i] <= {si[i], mod_q[i][L-1:1]};
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog R3 actual %0d cycles expected fewer", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] exp_mask(input logic [L-1:0] a, input logic [L-1:0] b,
                                          input logic [L-1:0] c);
    logic [2:0] m = '0;
    for (int k = 0; k < L; k++) begin
      if (b[k] == c[k] && a[k] != b[k]) m[0] = 1'b1;
      if (a[k] == c[k] && b[k] != a[k]) m[1] = 1'b1;
      if (a[k] == b[k] && c[k] != a[k]) m[2] = 1'b1;
    end
    return m;
  endfunction

  task automatic inject(input logic [L-1:0] f0, input logic [L-1:0] f1, input logic [L-1:0] f2);
    @(negedge clk);
    flip[0] = f0; flip[1] = f1; flip[2] = f2; inj_v = 1'b1;
    @(negedge clk);
    inj_v = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  // kind: 0 error, 1 checkpoint, 2 both (R9); poke: request mid-pass (R8)
  task automatic run_op(input int kind, input bit poke);
    logic [L-1:0] s0 [3];
    logic [2:0] em, got_m;
    int src, ncmp, nrec, n;
    bit route_ok, done;
    for (int i = 0; i < 3; i++) s0[i] = mod_q[i];
    em = exp_mask(s0[0], s0[1], s0[2]);
    src = !em[0] ? 0 : (!em[1] ? 1 : 2);
    @(negedge clk);
    err_req = (kind != 1);
    chkpt   = (kind != 0);
    @(negedge clk);
    err_req = 1'b0; chkpt = 1'b0;
    ncmp = 0; nrec = 0; n = 0; route_ok = 1'b1; done = 1'b0; got_m = '0;
    while (!done && n < 4 * L + 10) begin
      if (phase == 2'd1) begin
        ncmp++;
        if (se != 3'b111 || si != so) route_ok = 1'b0;
        if (poke && ncmp == 3) err_req = 1'b1;
      end else if (phase == 2'd2) begin
        if (nrec == 0) got_m = mask;
        nrec++;
        for (int i = 0; i < 3; i++)
          if (se[i] != 1'b1 || si[i] != (em[i] ? so[src] : so[i])) route_ok = 1'b0;
        if (poke && nrec == L) chkpt = 1'b1;
      end else begin
        done = 1'b1;
      end
      if (!done) begin
        @(negedge clk);
        err_req = 1'b0; chkpt = 1'b0;
        n++;
      end
    end
    chk(ncmp == L, "R3 comparison length", ncmp, L);
    chk(route_ok, "R3/R6 scan routing", route_ok, 1);
    if (em == 3'b000) begin
      chk(phase == 2'd0 && nrec == 0, "R5 direct return", {phase, 4'(nrec)}, 0);
      for (int i = 0; i < 3; i++)
        chk(mod_q[i] == s0[i], "R5 state preserved", mod_q[i], s0[i]);
    end else if (em == 3'b111) begin
      chk(phase == 2'd3 && halt, "R7 halted", {phase, halt}, 3'b111);
      repeat (3) @(negedge clk);
      chk(phase == 2'd3 && se == 3'b000 && mask == 3'b111, "R7 stays halted",
          {phase, se, mask}, {2'd3, 3'b000, 3'b111});
      for (int i = 0; i < 3; i++)
        chk(mod_q[i] == s0[i], "R7 state untouched", mod_q[i], s0[i]);
    end else begin
      chk(got_m == em, "R4 fault mask", got_m, em);
      chk(nrec == L, "R6 repair length", nrec, L);
      for (int i = 0; i < 3; i++)
        chk(mod_q[i] == s0[src], "R6 repaired state", mod_q[i], s0[src]);
    end
    if (em != 3'b111) begin
      chk(mask == 3'b000, "R8 mask cleared", mask, 0);
      repeat (2) @(negedge clk);
      chk(phase == 2'd0 && se == 3'b000, "R8 no re-entry", {phase, se}, 0);
    end
  endtask

  task automatic resync();
    inject('0, mod_q[0] ^ mod_q[1], mod_q[0] ^ mod_q[2]);
  endtask

  initial begin
    logic [L-1:0] f [3];
    logic [L-1:0] keep [3];
    void'($urandom(32'h5eed_1234));
    mod_q[0] = 8'hA5; mod_q[1] = 8'hA5; mod_q[2] = 8'hA5;
    flip[0] = '0; flip[1] = '0; flip[2] = '0;
    repeat (3) @(negedge clk);
    chk(phase == 2'd0 && se == 3'b000 && si == 3'b000 && !halt && mask == 3'b000,
        "R1 reset state", {phase, se, si, halt, mask}, 0);
    rst_ni = 1'b1;
    for (int i = 0; i < 3; i++) keep[i] = mod_q[i];
    repeat (5) @(negedge clk);
    chk(phase == 2'd0 && se == 3'b000, "R2 idle", {phase, se}, 0);
    chk(mod_q[1] == keep[1], "R2 state held", mod_q[1], keep[1]);

    run_op(1, 1'b0);                               // R5 checkpoint, clean
    inject('0, 8'h10, '0);   run_op(0, 1'b0);      // R6 single fault
    inject(8'h04, '0, 8'h20); run_op(2, 1'b1);     // R6 two faults, R9, R8
    inject(8'h01, 8'h40, 8'h08); run_op(0, 1'b0);  // R7 all faulty
    do_reset();
    chk(phase == 2'd0 && !halt, "R1 reset leaves halt", {phase, halt}, 0);
    resync();

    for (int it = 0; it < 40; it++) begin
      for (int i = 0; i < 3; i++)
        f[i] = ($urandom_range(0, 2) == 0) ? L'($urandom & $urandom & $urandom) : '0;
      inject(f[0], f[1], f[2]);
      run_op(int'($urandom_range(0, 2)), bit'($urandom_range(0, 1)));
      if (halt) begin
        do_reset();
        resync();
      end
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule